// File: doc/BRIEF.md
# Taken-Only Branch Target Buffer

This block sits in the instruction fetch stage and guesses the next fetch address from the address being fetched now. The fetch address is looked up in a small two-way set-associative table in the same cycle. When an entry matches, the stored target is placed on the next-address output, so the target can be fetched in the very next cycle with no lost cycle. When nothing matches, the output is the fetch address plus four, which is plain sequential fetch.

The table only ever holds branches that were resolved as taken, so a match is itself the prediction "taken". Branch resolution reports back through an update port that carries the branch address, its resolved target and its direction. A taken branch that misses is allocated. A taken branch that matches with a new target has its target rewritten. A matching branch that went not-taken loses its entry. A flush input, raised when the address space changes, empties the whole table. The penalty for a wrong guess is paid by the surrounding pipeline and is not part of this block.

With the default parameters there are 128 sets of two ways, so 256 entries. The set is chosen by address bits [8:2] and the tag is bits [31:9]. Each set has one replacement bit.

Top module: `btb_taken_only`

## Requirements
- R1: After reset, every lookup misses: `pred_hit` is 0 and `pred_next_pc` equals `fetch_pc + 4`, until the first taken update.
- R2: On a lookup that matches no valid entry, `pred_hit` is 0 and `pred_next_pc` is `fetch_pc + 4`, with all 32 bits of `fetch_pc` carried into the sum.
- R3: A taken update (`upd_en`=1, `upd_taken`=1, `flush`=0) for a branch that has no entry allocates one. From the next cycle on, a lookup of that branch gives `pred_hit`=1 and `pred_next_pc` equal to `upd_target` with bits [1:0] forced to 0.
- R4: When a lookup and an update happen in the same cycle, the lookup sees the table as it was before that update.
- R5: A taken update for a branch that already has an entry replaces the stored target with the new one. No second entry is made.
- R6: A not-taken update for a branch that has an entry invalidates it. Its lookups miss from the next cycle on.
- R7: A not-taken update for a branch that has no entry changes nothing: its lookups still miss, and the entries already in the table keep hitting.
- R8: The set index is address bits [8:2] and the tag is bits [31:9]. Bits [1:0] of `fetch_pc` and `upd_pc` take no part in matching.
- R9: An allocation goes into way 0 if way 0 is invalid, otherwise into way 1 if way 1 is invalid. Otherwise it evicts the way named by the set's replacement bit. Each allocation or target rewrite points that bit at the other way. An invalidation leaves the bit unchanged. Reset and flush clear the bit to way 0.
- R10: While `flush` is 1, the lookup in that cycle still sees the old contents. From the next cycle on, every entry is invalid, and an update in the flush cycle is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears all entries |
| fetch_pc | input | 32 | Address being fetched this cycle |
| pred_next_pc | output | 32 | Predicted next fetch address |
| pred_hit | output | 1 | Lookup matched a taken entry |
| upd_en | input | 1 | Resolved branch report valid |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_target | input | 32 | Resolved target address |
| upd_taken | input | 1 | Branch resolved taken |
| flush | input | 1 | Address space change: invalidate every entry |

## Verification
Directed sequences work on one set with three and four conflicting tags. They separate allocation into an invalid way from eviction through the replacement bit, and a target rewrite from a duplicate allocation. They also show that an invalidation leaves other entries intact and that a missing not-taken branch is ignored. Lookups are issued in the same cycle as updates and flushes of the same address, which separates pre-update contents from post-update contents. Lookups with low address bits set show that those bits play no part in matching. A long random run draws from twelve addresses that share three sets. It mixes updates, directions, targets and rare flushes, and compares every cycle against a behavioural model.

// File: rtl/btb_pkg.sv
package btb_pkg;
  typedef enum logic [1:0] {
    UPD_NONE    = 2'd0,
    UPD_REFRESH = 2'd1,
    UPD_DROP    = 2'd2,
    UPD_ALLOC   = 2'd3
  } upd_kind_e;
endpackage

// File: rtl/btb_way.sv
module btb_way #(
  parameter int ADDR_W   = 32,
  parameter int SET_BITS = 7
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush,
  input  logic [SET_BITS-1:0]        look_set,
  input  logic [ADDR_W-SET_BITS-3:0] look_tag,
  output logic                       look_hit,
  output logic [ADDR_W-3:0]          look_tgt,
  input  logic [SET_BITS-1:0]        upd_set,
  input  logic [ADDR_W-SET_BITS-3:0] upd_tag,
  output logic                       probe_hit,
  output logic                       probe_valid,
  input  logic                       wr_en,
  input  logic                       clr_en,
  input  logic [ADDR_W-3:0]          wr_tgt
);
  localparam int TAG_W = ADDR_W - SET_BITS - 2;
  localparam int SETS  = 1 << SET_BITS;

  logic [SETS-1:0]   valid_q;
  logic [TAG_W-1:0]  tag_mem [SETS];
  logic [ADDR_W-3:0] tgt_mem [SETS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      valid_q <= '0;
    else if (flush)  valid_q <= '0;
    else if (wr_en)  valid_q[upd_set] <= 1'b1;
    else if (clr_en) valid_q[upd_set] <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (wr_en && !flush) begin
      tag_mem[upd_set] <= upd_tag;
      tgt_mem[upd_set] <= wr_tgt;
    end
  end

  assign look_hit    = valid_q[look_set] && (tag_mem[look_set] == look_tag);
  assign look_tgt    = tgt_mem[look_set];
  assign probe_valid = valid_q[upd_set];
  assign probe_hit   = probe_valid && (tag_mem[upd_set] == upd_tag);
endmodule

// File: rtl/btb_lru.sv
module btb_lru #(
  parameter int SET_BITS = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                flush,
  input  logic                touch_en,
  input  logic [SET_BITS-1:0] touch_set,
  input  logic                touch_way,
  output logic                victim_way
);
  localparam int SETS = 1 << SET_BITS;

  logic [SETS-1:0] lru_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        lru_q <= '0;
    else if (flush)    lru_q <= '0;
    else if (touch_en) lru_q[touch_set] <= ~touch_way;
  end

  assign victim_way = lru_q[touch_set];
endmodule

// File: rtl/btb_upd_ctrl.sv
module btb_upd_ctrl
  import btb_pkg::*;
(
  input  logic       upd_en,
  input  logic       upd_taken,
  input  logic       flush,
  input  logic [1:0] probe_hit,
  input  logic [1:0] probe_valid,
  input  logic       victim_way,
  output upd_kind_e  kind,
  output logic [1:0] wr_en,
  output logic [1:0] clr_en,
  output logic       touch_en,
  output logic       chosen_way
);
  function automatic logic pick_fill(input logic [1:0] vld, input logic lru);
    if (!vld[0])      return 1'b0;
    else if (!vld[1]) return 1'b1;
    else              return lru;
  endfunction

  logic any_hit;
  assign any_hit = |probe_hit;

  always_comb begin
    if (!upd_en || flush) kind = UPD_NONE;
    else if (any_hit)     kind = upd_taken ? UPD_REFRESH : UPD_DROP;
    else                  kind = upd_taken ? UPD_ALLOC : UPD_NONE;
  end

  assign chosen_way = any_hit ? probe_hit[1] : pick_fill(probe_valid, victim_way);
  assign touch_en   = (kind == UPD_REFRESH) || (kind == UPD_ALLOC);

  always_comb begin
    for (int w = 0; w < 2; w++) begin
      wr_en[w]  = touch_en && (chosen_way == w[0]);
      clr_en[w] = (kind == UPD_DROP) && (chosen_way == w[0]);
    end
  end
endmodule

// File: rtl/btb_taken_only.sv
module btb_taken_only
  import btb_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int SET_BITS = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] fetch_pc,
  output logic [ADDR_W-1:0] pred_next_pc,
  output logic              pred_hit,
  input  logic              upd_en,
  input  logic [ADDR_W-1:0] upd_pc,
  input  logic [ADDR_W-1:0] upd_target,
  input  logic              upd_taken,
  input  logic              flush
);
  localparam int TAG_W = ADDR_W - SET_BITS - 2;
  localparam int WAYS  = 2;

  function automatic logic [SET_BITS-1:0] set_of(input logic [ADDR_W-1:0] pc);
    return pc[SET_BITS+1:2];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] pc);
    return pc[ADDR_W-1:SET_BITS+2];
  endfunction

  function automatic logic [ADDR_W-1:0] seq_next(input logic [ADDR_W-1:0] pc);
    return pc + ADDR_W'(4);
  endfunction

  logic [WAYS-1:0]   way_hit;
  logic [ADDR_W-3:0] way_tgt [WAYS];
  logic [WAYS-1:0]   probe_hit, probe_valid, wr_en, clr_en;
  logic              victim_way, touch_en, chosen_way;
  logic [ADDR_W-3:0] hit_tgt;
  upd_kind_e         upd_kind;
  logic              unused_low_bits;

  assign unused_low_bits = ^{upd_pc[1:0], upd_target[1:0]};

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    btb_way #(.ADDR_W(ADDR_W), .SET_BITS(SET_BITS)) u_way (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush      (flush),
      .look_set   (set_of(fetch_pc)),
      .look_tag   (tag_of(fetch_pc)),
      .look_hit   (way_hit[w]),
      .look_tgt   (way_tgt[w]),
      .upd_set    (set_of(upd_pc)),
      .upd_tag    (tag_of(upd_pc)),
      .probe_hit  (probe_hit[w]),
      .probe_valid(probe_valid[w]),
      .wr_en      (wr_en[w]),
      .clr_en     (clr_en[w]),
      .wr_tgt     (upd_target[ADDR_W-1:2])
    );
  end

  btb_lru #(.SET_BITS(SET_BITS)) u_lru (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .touch_en  (touch_en),
    .touch_set (set_of(upd_pc)),
    .touch_way (chosen_way),
    .victim_way(victim_way)
  );

  btb_upd_ctrl u_ctrl (
    .upd_en     (upd_en),
    .upd_taken  (upd_taken),
    .flush      (flush),
    .probe_hit  (probe_hit),
    .probe_valid(probe_valid),
    .victim_way (victim_way),
    .kind       (upd_kind),
    .wr_en      (wr_en),
    .clr_en     (clr_en),
    .touch_en   (touch_en),
    .chosen_way (chosen_way)
  );

  always_comb begin
    hit_tgt = '0;
    for (int w = WAYS - 1; w >= 0; w--)
      if (way_hit[w]) hit_tgt = way_tgt[w];
  end

  assign pred_hit     = |way_hit;
  assign pred_next_pc = pred_hit ? {hit_tgt, 2'b00} : seq_next(fetch_pc);
endmodule

// File: rtl/btb_checker.sv
module btb_checker
  import btb_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] fetch_pc,
  input logic [ADDR_W-1:0] pred_next_pc,
  input logic              pred_hit,
  input logic              upd_en,
  input logic [ADDR_W-1:0] upd_pc,
  input logic [ADDR_W-1:0] upd_target,
  input logic              upd_taken,
  input logic              flush,
  input logic [1:0]        way_hit,
  input upd_kind_e         upd_kind
);
  AST_SINGLE_WAY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(way_hit)); // R5

  AST_TAKEN_THEN_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && upd_taken && !flush) |=>
      ((fetch_pc[ADDR_W-1:2] != $past(upd_pc[ADDR_W-1:2])) ||
       (pred_hit && pred_next_pc == {$past(upd_target[ADDR_W-1:2]), 2'b00}))); // R3

  AST_DROP_THEN_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_kind == UPD_DROP) |=>
      ((fetch_pc[ADDR_W-1:2] != $past(upd_pc[ADDR_W-1:2])) || !pred_hit)); // R6

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !pred_hit); // R10
endmodule

bind btb_taken_only btb_checker #(.ADDR_W(ADDR_W)) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .fetch_pc    (fetch_pc),
  .pred_next_pc(pred_next_pc),
  .pred_hit    (pred_hit),
  .upd_en      (upd_en),
  .upd_pc      (upd_pc),
  .upd_target  (upd_target),
  .upd_taken   (upd_taken),
  .flush       (flush),
  .way_hit     (way_hit),
  .upd_kind    (upd_kind)
);

// File: tb/test_btb_taken_only.sv
`timescale 1ns/1ps
module test_btb_taken_only;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] fetch_pc = '0, upd_pc = '0, upd_target = '0;
  logic        upd_en = 1'b0, upd_taken = 1'b0, flush = 1'b0;
  logic [31:0] pred_next_pc;
  logic        pred_hit;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  btb_taken_only i_btb_taken_only (
    .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc),
    .pred_next_pc(pred_next_pc), .pred_hit(pred_hit),
    .upd_en(upd_en), .upd_pc(upd_pc), .upd_target(upd_target),
    .upd_taken(upd_taken), .flush(flush)
  );

  // behavioural reference: per set, two slots and a victim bit
  bit          mv   [128][2];
  int unsigned mtag [128][2];
  int unsigned mtgt [128][2];
  bit          mlru [128];

  task automatic model_clear();
    for (int s = 0; s < 128; s++) begin
      mlru[s] = 0;
      for (int w = 0; w < 2; w++) mv[s][w] = 0;
    end
  endtask

  task automatic model_look(input logic [31:0] pc, output bit h, output logic [31:0] nx);
    int s = int'(pc[8:2]);
    h  = 0;
    nx = pc + 32'd4;
    for (int w = 0; w < 2; w++)
      if (mv[s][w] && mtag[s][w] == pc[31:9]) begin
        h  = 1;
        nx = mtgt[s][w];
      end
  endtask

  task automatic model_update(input bit ue, input logic [31:0] upc, utgt, input bit tk, fl);
    int s = int'(upc[8:2]);
    int f = -1;
    if (fl) begin model_clear(); return; end
    if (!ue) return;
    for (int w = 0; w < 2; w++)
      if (mv[s][w] && mtag[s][w] == upc[31:9]) f = w;
    if (f >= 0) begin
      if (tk) begin mtgt[s][f] = {utgt[31:2], 2'b00}; mlru[s] = (f == 0); end
      else mv[s][f] = 0;
    end else if (tk) begin
      if (!mv[s][0]) f = 0;
      else if (!mv[s][1]) f = 1;
      else f = mlru[s] ? 1 : 0;
      mv[s][f]   = 1;
      mtag[s][f] = upc[31:9];
      mtgt[s][f] = {utgt[31:2], 2'b00};
      mlru[s]    = (f == 0);
    end
  endtask

  task automatic step(input logic [31:0] pc, input bit ue, input logic [31:0] upc, utgt,
                      input bit tk, fl, input string rq);
    bit eh;
    logic [31:0] en;
    @(negedge clk);
    fetch_pc = pc; upd_en = ue; upd_pc = upc; upd_target = utgt;
    upd_taken = tk; flush = fl;
    #2;
    model_look(pc, eh, en);
    checks++;
    if (pred_hit !== eh || pred_next_pc !== en) begin
      fails++;
      $display("FAIL %s pc=%h: hit=%0b next=%h expected hit=%0b next=%h",
               rq, pc, pred_hit, pred_next_pc, eh, en);
    end
    @(posedge clk);
    model_update(ue, upc, utgt, tk, fl);
  endtask

  task automatic look(input logic [31:0] pc, input string rq);
    step(pc, 0, 32'h0, 32'h0, 0, 0, rq);
  endtask

  localparam logic [31:0] PA = 32'h0000_1000, PB = 32'h0000_2000,
                          PC = 32'h0000_3000, PD = 32'h0000_4000,
                          PE = 32'h0000_5000, PF = 32'h0000_6000;

  initial begin
    #3000000;
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    model_clear();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1: empty table after reset
    look(PA, "R1");
    look(32'hFFFF_FFFC, "R1");
    // R2: plain miss, including odd low bits
    look(32'h0000_0123, "R2");
    // R4: lookup in the cycle of the allocating update still misses
    step(PA, 1, PA, 32'h0000_8000, 1, 0, "R4");
    // R3: hit from the next cycle
    look(PA, "R3");
    // R8: low bits ignored on lookup and on update
    look(PA | 32'h3, "R8");
    step(PA, 1, PA | 32'h2, 32'h0000_9003, 1, 0, "R8");
    // R5: target rewrite visible the cycle after
    look(PA, "R5");
    look(PA + 32'h200, "R8");
    // R9: fill way 1, then evict the replacement victim (PA)
    step(PB, 1, PB, 32'h0000_A000, 1, 0, "R9");
    step(PC, 1, PC, 32'h0000_B000, 1, 0, "R9");
    look(PA, "R9");
    look(PB, "R9");
    look(PC, "R9");
    // R6: invalidate PC; PB stays
    step(PC, 1, PC, 32'h0, 0, 0, "R6");
    look(PC, "R6");
    look(PB, "R6");
    // R9: invalid way filled before the victim bit's way
    step(PD, 1, PD, 32'h0000_C000, 1, 0, "R9");
    look(PB, "R9");
    look(PD, "R9");
    // R7: not-taken miss leaves everything alone
    step(PE, 1, PE, 32'h0000_D000, 0, 0, "R7");
    look(PE, "R7");
    look(PB, "R7");
    look(PD, "R7");
    // R10: flush with a simultaneous update
    step(PB, 1, PF, 32'h0000_E000, 1, 1, "R10");
    look(PB, "R10");
    look(PD, "R10");
    look(PF, "R10");
    // random mix over 12 addresses sharing 3 sets (R3 R5 R6 R9 R10)
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] p, u, t;
      bit ue, tk, fl;
      p  = ({28'h0, 4'(($urandom % 4) + 1)} << 9) | ((32'($urandom % 3)) << 2) | 32'($urandom % 4);
      u  = ({28'h0, 4'(($urandom % 4) + 1)} << 9) | ((32'($urandom % 3)) << 2);
      t  = $urandom;
      ue = ($urandom % 2) == 0;
      tk = ($urandom % 3) != 0;
      fl = ($urandom % 200) == 0;
      step(p, ue, u, t, tk, fl, "random R3 R5 R6 R9");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule